// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps time of day and calendar in packed BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. A free-running prescaler divides the system clock down to one advance per second. Every carry from seconds up to the year is resolved in the same clock edge. A control input held low lets the clock run. Holding it high freezes the registers and the prescaler.

The hours register works in two modes. Bit 6 selects the mode. In 12-hour mode, bit 5 is a PM flag. In 24-hour mode, bit 5 is the twenties digit. A write port loads any register at once, and a combinational read port returns any register. Each automatic advance of the seconds raises a one-cycle strobe for alarm logic further downstream. Bits that the calendar never uses are held at zero, however they are written.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset, the registers read as follows: seconds 00h, minutes 00h, hours 00h (24-hour midnight), day 01h, date 01h, month 01h and year 00h. `sec_pulse` is 0. Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month and 6 year.
- R2: While `run_n` is 0, the seconds advance once every `TICKS_PER_SEC` clock cycles. `sec_pulse` is 1 for exactly the one cycle in which the new seconds value first appears on the read port.
- R3: While `run_n` is 1, no register changes except by a write, the prescaler holds its count, and `sec_pulse` stays 0.
- R4: Seconds and minutes count in BCD from 00 to 59. The step from 09 goes to 10. The step from 59 goes to 00 and carries into the next field.
- R5: When hours bit 6 is 0 (24-hour mode), bits 5..0 hold BCD 00 to 23. The step past 23:59:59 gives 00:00:00 and advances the day and the date.
- R6: When hours bit 6 is 1 (12-hour mode), bits 4..0 hold BCD 01 to 12 and bit 5 is PM. The step from 11 goes to 12 and toggles PM. The step from 12 goes to 01. The step past 11:59:59 PM also advances the day and the date.
- R7: The day of week counts 1 to 7, and the step after 7 goes to 1.
- R8: The date wraps to 01 after day 30 of months 04, 06, 09 and 11, and after day 31 of the other long months, and then advances the month. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: February wraps after day 29 when the year value is divisible by 4, and after day 28 otherwise.
- R10: Some bits always read 0: bit 7 of seconds, minutes and hours; bits 7..3 of day; bits 7..6 of date; bits 7..5 of month. Address 7 reads 0 and ignores writes.
- R11: A write is visible on the read port in the next cycle. A write cycle suppresses any advance due in that cycle. A write to the seconds restarts the prescaler, so the next advance comes `TICKS_PER_SEC` running cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_n | input | 1 | Counting enable, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for reads |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| sec_pulse | output | 1 | One-cycle strobe on each automatic seconds advance |

## Verification
A bad carry condition shows up within a single second. The wrong field reads back in the cycle right after the strobe: for example, an hour that reads 13 in 12-hour mode, a missing date step at 23:59:59, or February 29 appearing in a non-leap year. A prescaler that slips shows as the strobe arriving a cycle early or late against the `TICKS_PER_SEC` count. A mode bit or zero bit that leaks through shows on the first read after the write that set it up. Each scenario therefore loads a boundary time, runs exactly one second, and reads every affected field.

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;
  logic [7:0] sec_r, min_r, hour_r, day_r, date_r, mon_r, year_r;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    logic [6:0] yb;
    yb = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    case (m)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  wire tick = !run_n && (cnt == LAST);
  wire adv  = tick && !wr_en;

  wire h12      = hour_r[6];
  wire pm       = hour_r[5];
  wire hour_end = h12 ? (hour_r[4:0] == 5'h11 && pm) : (hour_r[5:0] == 6'h23);

  wire c_min  = adv   && (sec_r  == 8'h59);
  wire c_hour = c_min && (min_r  == 8'h59);
  wire c_day  = c_hour && hour_end;
  wire c_mon  = c_day && (date_r == month_end(mon_r, year_r));
  wire c_year = c_mon && (mon_r  == 8'h12);

  logic [7:0] hour_nx;
  always_comb begin
    if (!h12)
      hour_nx = (hour_r[5:0] == 6'h23) ? 8'h00 : {2'b00, bcd_inc({2'b00, hour_r[5:0]})[5:0]};
    else if (hour_r[4:0] == 5'h12)
      hour_nx = {2'b01, pm, 5'h01};
    else if (hour_r[4:0] == 5'h11)
      hour_nx = {2'b01, ~pm, 5'h12};
    else
      hour_nx = {2'b01, pm, bcd_inc({3'b000, hour_r[4:0]})[4:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; sec_pulse <= 1'b0;
      sec_r <= 8'h00; min_r <= 8'h00; hour_r <= 8'h00; day_r <= 8'h01;
      date_r <= 8'h01; mon_r <= 8'h01; year_r <= 8'h00;
    end else begin
      sec_pulse <= adv;
      if (wr_en && wr_addr == 3'd0) cnt <= '0;
      else if (!run_n)              cnt <= tick ? '0 : cnt + 1'b1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: sec_r  <= {1'b0, wr_data[6:0]};
          3'd1: min_r  <= {1'b0, wr_data[6:0]};
          3'd2: hour_r <= {1'b0, wr_data[6:0]};
          3'd3: day_r  <= {5'b0, wr_data[2:0]};
          3'd4: date_r <= {2'b0, wr_data[5:0]};
          3'd5: mon_r  <= {3'b0, wr_data[4:0]};
          3'd6: year_r <= wr_data;
          default: ;
        endcase
      end else begin
        if (adv)    sec_r  <= (sec_r == 8'h59) ? 8'h00 : bcd_inc(sec_r);
        if (c_min)  min_r  <= (min_r == 8'h59) ? 8'h00 : bcd_inc(min_r);
        if (c_hour) hour_r <= hour_nx;
        if (c_day) begin
          day_r  <= (day_r == 8'h07) ? 8'h01 : day_r + 8'h01;
          date_r <= (date_r == month_end(mon_r, year_r)) ? 8'h01 : bcd_inc(date_r);
        end
        if (c_mon)  mon_r  <= (mon_r == 8'h12) ? 8'h01 : bcd_inc(mon_r);
        if (c_year) year_r <= (year_r == 8'h99) ? 8'h00 : bcd_inc(year_r);
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0: rd_data = sec_r;
      3'd1: rd_data = min_r;
      3'd2: rd_data = hour_r;
      3'd3: rd_data = day_r;
      3'd4: rd_data = date_r;
      3'd5: rd_data = mon_r;
      3'd6: rd_data = year_r;
      default: rd_data = 8'h00;
    endcase
  end

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && !wr_en) |=> ($stable(sec_r) && $stable(min_r) && !sec_pulse));

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> $past(!run_n && !wr_en));

  // R2
  pulse_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (sec_r != $past(sec_r)));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd2) |=> $stable(hour_r[6]));
endmodule

// File: tb/test_bcd_clock_calendar.sv
`timescale 1ns/1ps
module test_bcd_clock_calendar;
  localparam int T = 4;

  logic clk = 1'b0, rst_n = 1'b0, run_n = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic sec_pulse;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [2:0] a; logic [7:0] v; string tag; } item_t;
  item_t q[$];

  bcd_clock_calendar #(.TICKS_PER_SEC(T)) i_bcd_clock_calendar (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sec_pulse(sec_pulse));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      rd_addr = it.a;
      #1;
      checks++;
      if (rd_data !== it.v) begin
        fails++;
        $display("FAIL %s addr %0d actual %h expected %h", it.tag, it.a, rd_data, it.v);
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] v, input string tag);
    item_t it;
    it.a = a; it.v = v; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic check_pulse(input logic exp, input string tag);
    checks++;
    if (sec_pulse !== exp) begin
      fails++;
      $display("FAIL %s sec_pulse actual %b expected %b", tag, sec_pulse, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_date(input logic [7:0] dy, dt, mo, yr);
    wr(3, dy); wr(4, dt); wr(5, mo); wr(6, yr);
  endtask

  task automatic set_time(input logic [7:0] h, m, s);
    wr(2, h); wr(1, m); wr(0, s);
  endtask

  task automatic step(input string tag);
    run_n = 1'b0;
    for (int i = 0; i < T - 1; i++) begin
      @(negedge clk);
      check_pulse(1'b0, tag);
    end
    @(negedge clk);
    run_n = 1'b1;
    check_pulse(1'b1, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_pulse(1'b0, "R1");
    expect_reg(0, 8'h00, "R1"); expect_reg(1, 8'h00, "R1"); expect_reg(2, 8'h00, "R1");
    expect_reg(3, 8'h01, "R1"); expect_reg(4, 8'h01, "R1"); expect_reg(5, 8'h01, "R1");
    expect_reg(6, 8'h00, "R1");
    expect_reg(7, 8'h00, "R10");

    // R2 one second
    step("R2");
    expect_reg(0, 8'h01, "R2");

    // R3 halted
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_pulse(1'b0, "R3");
    end
    expect_reg(0, 8'h01, "R3");

    // R4 BCD digit carry
    set_time(8'h10, 8'h09, 8'h09);
    step("R4"); expect_reg(0, 8'h10, "R4"); expect_reg(1, 8'h09, "R4");
    set_time(8'h10, 8'h09, 8'h59);
    step("R4"); expect_reg(0, 8'h00, "R4"); expect_reg(1, 8'h10, "R4");

    // R5 R7 R8 full rollover in 24h mode
    set_date(8'h07, 8'h31, 8'h12, 8'h99);
    set_time(8'h23, 8'h59, 8'h59);
    step("R5");
    expect_reg(2, 8'h00, "R5"); expect_reg(1, 8'h00, "R5"); expect_reg(0, 8'h00, "R5");
    expect_reg(3, 8'h01, "R7"); expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h01, "R8"); expect_reg(6, 8'h00, "R8");
    set_time(8'h19, 8'h59, 8'h59);
    step("R5"); expect_reg(2, 8'h20, "R5"); expect_reg(4, 8'h01, "R5");

    // R6 12h mode
    set_time(8'h51, 8'h59, 8'h59);
    step("R6"); expect_reg(2, 8'h72, "R6");
    set_time(8'h72, 8'h59, 8'h59);
    step("R6"); expect_reg(2, 8'h61, "R6");
    set_date(8'h03, 8'h15, 8'h06, 8'h21);
    set_time(8'h71, 8'h59, 8'h59);
    step("R6"); expect_reg(2, 8'h52, "R6"); expect_reg(4, 8'h16, "R6"); expect_reg(3, 8'h04, "R7");
    set_time(8'h52, 8'h59, 8'h59);
    step("R6"); expect_reg(2, 8'h41, "R6"); expect_reg(4, 8'h16, "R6");

    // R8 month lengths
    set_date(8'h02, 8'h30, 8'h04, 8'h21);
    set_time(8'h23, 8'h59, 8'h59);
    step("R8"); expect_reg(4, 8'h01, "R8"); expect_reg(5, 8'h05, "R8");
    set_date(8'h02, 8'h30, 8'h09, 8'h21);
    set_time(8'h23, 8'h59, 8'h59);
    step("R8"); expect_reg(4, 8'h01, "R8"); expect_reg(5, 8'h10, "R8");
    set_date(8'h02, 8'h30, 8'h07, 8'h21);
    set_time(8'h23, 8'h59, 8'h59);
    step("R8"); expect_reg(4, 8'h31, "R8"); expect_reg(5, 8'h07, "R8");

    // R9 February
    set_date(8'h02, 8'h28, 8'h02, 8'h24);
    set_time(8'h23, 8'h59, 8'h59);
    step("R9"); expect_reg(4, 8'h29, "R9"); expect_reg(5, 8'h02, "R9");
    set_time(8'h23, 8'h59, 8'h59);
    step("R9"); expect_reg(4, 8'h01, "R9"); expect_reg(5, 8'h03, "R9");
    set_date(8'h02, 8'h28, 8'h02, 8'h23);
    set_time(8'h23, 8'h59, 8'h59);
    step("R9"); expect_reg(4, 8'h01, "R9"); expect_reg(5, 8'h03, "R9");
    set_date(8'h02, 8'h28, 8'h02, 8'h10);
    set_time(8'h23, 8'h59, 8'h59);
    step("R9"); expect_reg(4, 8'h01, "R9");
    set_date(8'h02, 8'h28, 8'h02, 8'h00);
    set_time(8'h23, 8'h59, 8'h59);
    step("R9"); expect_reg(4, 8'h29, "R9");

    // R10 fixed-zero bits
    for (int a = 0; a < 8; a++) wr(3'(a), 8'hFF);
    expect_reg(0, 8'h7F, "R10"); expect_reg(1, 8'h7F, "R10"); expect_reg(2, 8'h7F, "R10");
    expect_reg(3, 8'h07, "R10"); expect_reg(4, 8'h3F, "R10"); expect_reg(5, 8'h1F, "R10");
    expect_reg(6, 8'hFF, "R10"); expect_reg(7, 8'h00, "R10");

    // R11 write restarts prescaler and suppresses the due advance
    set_date(8'h01, 8'h01, 8'h01, 8'h00);
    set_time(8'h00, 8'h00, 8'h00);
    expect_reg(0, 8'h00, "R11");
    run_n = 1'b0;
    repeat (T - 2) @(negedge clk);
    wr(0, 8'h20);
    check_pulse(1'b0, "R11");
    repeat (T - 1) @(negedge clk);
    run_n = 1'b1;
    check_pulse(1'b0, "R11");
    expect_reg(0, 8'h20, "R11");
    run_n = 1'b0;
    @(negedge clk);
    run_n = 1'b1;
    check_pulse(1'b1, "R11");
    expect_reg(0, 8'h21, "R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule